// File: doc/BRIEF.md
# Quarter-Rate Quadrature Carrier Correlator

This block pulls the amplitude and phase of a single carrier out of a stream of ADC samples. The samples are taken at exactly four times the carrier frequency, so every run of four samples spans one carrier cycle. Because of that ratio, the sine and cosine references take only the values 0, +1 and -1, and the products reduce to selecting, negating or dropping a sample. Each cycle gives one sine-channel sum and one cosine-channel sum. Each sum slides through its own ring of `WIN` entries, and a running total of each ring is kept.

After each cycle a small state machine takes the two totals. It forms the magnitude with a bit-serial integer square root. It then forms a normalised phase term, which is the sine total divided by that magnitude, with a bit-serial divider. The results are registered and held until the next cycle.

The states are `ST_WAIT`, `ST_ROOT`, `ST_DIV` and `ST_EMIT`:
- `ST_WAIT` to `ST_ROOT` happens when both rings report an update. At that point the totals are latched and the root is started.
- `ST_ROOT` to `ST_DIV` happens when the root finishes. The magnitude is latched and the divide is started.
- `ST_DIV` to `ST_EMIT` happens when the divide finishes.
- `ST_EMIT` returns to `ST_WAIT` unconditionally, after the outputs are written.

Samples must be spaced at least 12 clocks apart. Under that condition, all the arithmetic for one cycle finishes inside the four sample periods of the next cycle.

Top module: `qcorr_top`

## Requirements
- R1: Each 12-bit unsigned code is converted to a signed value by subtracting the mid-scale value 2048 before it is correlated.
- R2: The first sample accepted after reset has group index 0, and the index then wraps through 0,1,2,3. The per-cycle cosine sum uses references +1,0,-1,0, so it equals s0 - s2.
- R3: The per-cycle sine sum uses references 0,+1,0,-1, so it equals s1 - s3.
- R4: Each per-cycle sum enters its own 120-entry ring. `sin_total` and `cos_total` equal the sum of the newest 120 entries of their ring, or of all entries written so far while the ring is not yet full.
- R5: Once a ring is full, each new entry replaces the oldest one. The running total adds the new entry and drops the one it overwrites.
- R6: `magnitude` equals floor(sqrt(sin_total^2 + cos_total^2)).
- R7: `mag_done` pulses for exactly one clock, once per completed carrier cycle. It pulses when the root finishes, and it finishes before the next group of four samples is complete.
- R8: `phase` equals sign(sin_total) * floor(|sin_total| * 2^15 / magnitude). It is 0 when `magnitude` is 0.
- R9: `res_valid` pulses once per cycle result, and only when both rings hold 120 entries. The totals, magnitude and phase outputs hold their values between results.
- R10: Reset empties both rings, clears both totals and all outputs, and returns the state machine to `ST_WAIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One ADC sample is present on `smp_code` |
| smp_code | input | 12 | Unsigned ADC code |
| mag_done | output | 1 | One-clock pulse when the magnitude of a cycle is ready |
| res_valid | output | 1 | One-clock pulse with a result from a full window |
| sin_total | output | 21 | Signed windowed sine-channel total |
| cos_total | output | 21 | Signed windowed cosine-channel total |
| magnitude | output | 21 | Vector magnitude of the two totals |
| phase | output | 17 | Signed sine total over magnitude, scaled by 2^15 |

## Verification
The main function is driven with several input patterns, and each one separates a different set of faults:
- A pure cosine-phase carrier and a pure sine-phase carrier separate the two reference sequences. They also expose any swap of sample index or channel.
- Full-scale codes of opposite sign reach the extremes of the totals and the square root. They also give a negative phase, which checks the sign handling.
- A steady DC level checks that the offset cancels and that a zero magnitude gives a zero phase.
- A switch from one carrier phase to the other after the window is full shows whether overwritten entries leave the totals.
- A short partial fill followed by a mid-run reset shows that `res_valid` waits for 120 entries and that reset empties the rings.

// File: rtl/qcorr_pkg.sv
package qcorr_pkg;

    // Sequencing of the per-cycle magnitude and phase computation
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_ROOT = 2'd1,
        ST_DIV  = 2'd2,
        ST_EMIT = 2'd3
    } qc_state_e;

    localparam int NUM_CH = 2;   // channel 0: sine, channel 1: cosine

endpackage

// File: rtl/qcorr_mixer.sv
module qcorr_mixer #(
    parameter int ADC_W = 12,
    parameter int SUM_W = ADC_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [ADC_W-1:0]        smp_code,
    output logic                    cyc_valid,
    output logic signed [SUM_W-1:0] sin_sum,
    output logic signed [SUM_W-1:0] cos_sum
);
    localparam int MID = 1 << (ADC_W - 1);

    logic [1:0]              idx;
    logic signed [ADC_W:0]   centred;
    logic signed [SUM_W-1:0] ext;
    logic signed [SUM_W-1:0] acc_s;
    logic signed [SUM_W-1:0] acc_c;

    // Offset removal: unsigned code minus mid-scale
    assign centred = $signed({1'b0, smp_code}) - $signed((ADC_W+1)'(MID));
    assign ext     = SUM_W'(centred);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            acc_s     <= '0;
            acc_c     <= '0;
            sin_sum   <= '0;
            cos_sum   <= '0;
            cyc_valid <= 1'b0;
        end else begin
            cyc_valid <= 1'b0;
            if (smp_valid) begin
                idx <= idx + 2'd1;
                unique case (idx)
                    2'd0: acc_c <= ext;            // cos ref +1
                    2'd1: acc_s <= ext;            // sin ref +1
                    2'd2: acc_c <= acc_c - ext;    // cos ref -1
                    2'd3: begin                    // sin ref -1, cycle complete
                        sin_sum   <= acc_s - ext;
                        cos_sum   <= acc_c;
                        cyc_valid <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/qcorr_window.sv
module qcorr_window #(
    parameter int SUM_W = 14,
    parameter int WIN   = 120,
    parameter int TOT_W = SUM_W + $clog2(WIN),
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic signed [SUM_W-1:0] din,
    output logic signed [TOT_W-1:0] total,
    output logic [CNT_W-1:0]        fill,
    output logic                    upd
);
    localparam int PTR_W = $clog2(WIN);

    logic signed [SUM_W-1:0] ring [WIN];
    logic [PTR_W-1:0]        wptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) ring[i] <= '0;
            wptr  <= '0;
            total <= '0;
            fill  <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= push;
            if (push) begin
                // the entry being overwritten leaves the total as the new one enters
                total      <= total + TOT_W'(din) - TOT_W'(ring[wptr]);
                ring[wptr] <= din;
                wptr       <= (wptr == PTR_W'(WIN - 1)) ? '0 : wptr + PTR_W'(1);
                if (fill != CNT_W'(WIN)) fill <= fill + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/qcorr_isqrt.sv
module qcorr_isqrt #(
    parameter int RAD_W  = 42,
    parameter int ROOT_W = RAD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RAD_W-1:0]  radicand,
    output logic              done,
    output logic [ROOT_W-1:0] root
);
    localparam int STEP_W = $clog2(ROOT_W + 1);

    logic [RAD_W-1:0]  rem;
    logic [RAD_W-1:0]  acc;
    logic [RAD_W-1:0]  bitv;
    logic [RAD_W-1:0]  trial;
    logic [STEP_W-1:0] steps;
    logic              running;

    assign trial = acc + bitv;
    assign root  = acc[ROOT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            acc     <= '0;
            bitv    <= '0;
            steps   <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem     <= radicand;
                acc     <= '0;
                bitv    <= RAD_W'(1) << (RAD_W - 2);
                steps   <= STEP_W'(ROOT_W);
                running <= 1'b1;
            end else if (running) begin
                if (rem >= trial) begin
                    rem <= rem - trial;
                    acc <= (acc >> 1) + bitv;
                end else begin
                    acc <= acc >> 1;
                end
                bitv  <= bitv >> 2;
                steps <= steps - STEP_W'(1);
                if (steps == STEP_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qcorr_ratio.sv
module qcorr_ratio #(
    parameter int NUM_W = 21,
    parameter int FRAC  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,    // must not exceed den
    input  logic [NUM_W-1:0] den,
    output logic             done,
    output logic [FRAC:0]    quot
);
    localparam int STEP_W = $clog2(FRAC + 2);

    logic [NUM_W:0]    rem;
    logic [NUM_W:0]    den_r;
    logic [NUM_W:0]    diff;
    logic              qbit;
    logic [STEP_W-1:0] steps;
    logic              running;

    assign qbit = (rem >= den_r);
    assign diff = qbit ? rem - den_r : rem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            den_r   <= '0;
            quot    <= '0;
            steps   <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem     <= {1'b0, num};
                den_r   <= {1'b0, den};
                quot    <= '0;
                steps   <= STEP_W'(FRAC + 1);
                running <= 1'b1;
            end else if (running) begin
                rem   <= diff << 1;
                quot  <= {quot[FRAC-1:0], qbit};
                steps <= steps - STEP_W'(1);
                if (steps == STEP_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qcorr_top.sv
module qcorr_top
    import qcorr_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int WIN   = 120,
    parameter int FRAC  = 15,
    localparam int SUM_W = ADC_W + 2,
    localparam int TOT_W = SUM_W + $clog2(WIN),
    localparam int PH_W  = FRAC + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [ADC_W-1:0]        smp_code,
    output logic                    mag_done,
    output logic                    res_valid,
    output logic signed [TOT_W-1:0] sin_total,
    output logic signed [TOT_W-1:0] cos_total,
    output logic [TOT_W-1:0]        magnitude,
    output logic signed [PH_W-1:0]  phase
);
    localparam int RAD_W = 2 * TOT_W;
    localparam int CNT_W = $clog2(WIN + 1);

    qc_state_e state, nxt;

    logic                    cyc_valid;
    logic signed [SUM_W-1:0] sums   [NUM_CH];
    logic signed [TOT_W-1:0] tot    [NUM_CH];
    logic [CNT_W-1:0]        fill_w [NUM_CH];
    logic [NUM_CH-1:0]       upd_w;
    logic                    win_upd;
    logic                    win_full;
    logic [CNT_W-1:0]        fill_cnt;

    logic signed [RAD_W-1:0] sq_s, sq_c;
    logic [RAD_W-1:0]        radicand;
    logic                    root_go, root_done;
    logic [TOT_W-1:0]        root_val;
    logic                    div_go, div_done;
    logic [FRAC:0]           quot;

    logic signed [TOT_W-1:0] lat_sin, lat_cos;
    logic [TOT_W-1:0]        lat_mag;
    logic [TOT_W-1:0]        num_abs;
    logic signed [PH_W-1:0]  ph_pos;

    qcorr_mixer #(.ADC_W(ADC_W), .SUM_W(SUM_W)) mixer_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .cyc_valid(cyc_valid), .sin_sum(sums[0]), .cos_sum(sums[1])
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_win
        qcorr_window #(.SUM_W(SUM_W), .WIN(WIN), .TOT_W(TOT_W), .CNT_W(CNT_W)) win_i (
            .clk(clk), .rst_n(rst_n), .push(cyc_valid), .din(sums[ch]),
            .total(tot[ch]), .fill(fill_w[ch]), .upd(upd_w[ch])
        );
    end

    assign win_upd  = &upd_w;
    assign win_full = (fill_w[0] == CNT_W'(WIN)) && (fill_w[1] == CNT_W'(WIN));
    assign fill_cnt = fill_w[0];

    // squared totals feed the root directly on the start edge
    assign sq_s     = RAD_W'(tot[0]) * RAD_W'(tot[0]);
    assign sq_c     = RAD_W'(tot[1]) * RAD_W'(tot[1]);
    assign radicand = RAD_W'(sq_s + sq_c);

    assign root_go  = (state == ST_WAIT) && win_upd;
    assign div_go   = (state == ST_ROOT) && root_done;
    assign num_abs  = lat_sin[TOT_W-1] ? TOT_W'(-lat_sin) : TOT_W'(lat_sin);
    assign ph_pos   = PH_W'(quot);

    qcorr_isqrt #(.RAD_W(RAD_W), .ROOT_W(TOT_W)) root_i (
        .clk(clk), .rst_n(rst_n), .start(root_go), .radicand(radicand),
        .done(root_done), .root(root_val)
    );

    qcorr_ratio #(.NUM_W(TOT_W), .FRAC(FRAC)) ratio_i (
        .clk(clk), .rst_n(rst_n), .start(div_go), .num(num_abs), .den(root_val),
        .done(div_done), .quot(quot)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: if (win_upd)   nxt = ST_ROOT;
            ST_ROOT: if (root_done) nxt = ST_DIV;
            ST_DIV:  if (div_done)  nxt = ST_EMIT;
            ST_EMIT:                nxt = ST_WAIT;
        endcase
    end

    // operand latches and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_sin   <= '0;
            lat_cos   <= '0;
            lat_mag   <= '0;
            mag_done  <= 1'b0;
            res_valid <= 1'b0;
            sin_total <= '0;
            cos_total <= '0;
            magnitude <= '0;
            phase     <= '0;
        end else begin
            mag_done  <= div_go;
            res_valid <= 1'b0;
            if (root_go) begin
                lat_sin <= tot[0];
                lat_cos <= tot[1];
            end
            if (div_go) lat_mag <= root_val;
            if (state == ST_EMIT) begin
                res_valid <= win_full;
                sin_total <= lat_sin;
                cos_total <= lat_cos;
                magnitude <= lat_mag;
                if (lat_mag == '0)        phase <= '0;
                else if (lat_sin[TOT_W-1]) phase <= -ph_pos;
                else                       phase <= ph_pos;
            end
        end
    end

endmodule

// File: rtl/qcorr_checker.sv
module qcorr_checker #(
    parameter int WIN   = 120,
    parameter int TOT_W = 21,
    parameter int FRAC  = 15,
    parameter int PH_W  = FRAC + 2,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mag_done,
    input logic                    res_valid,
    input logic signed [TOT_W-1:0] sin_total,
    input logic signed [TOT_W-1:0] cos_total,
    input logic [TOT_W-1:0]        magnitude,
    input logic signed [PH_W-1:0]  phase,
    input logic [CNT_W-1:0]        fill_cnt
);
    localparam logic signed [PH_W-1:0] PLIM = PH_W'(1 << FRAC);

    logic [TOT_W-1:0] abs_sin, abs_cos;
    assign abs_sin = sin_total[TOT_W-1] ? TOT_W'(-sin_total) : TOT_W'(sin_total);
    assign abs_cos = cos_total[TOT_W-1] ? TOT_W'(-cos_total) : TOT_W'(cos_total);

    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(WIN));                                              // R4
    AST_VALID_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (fill_cnt == CNT_W'(WIN)));                              // R9
    AST_MAG_COVERS_SIN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (magnitude >= abs_sin));                                 // R6
    AST_MAG_COVERS_COS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (magnitude >= abs_cos));                                 // R6
    AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (phase <= PLIM && phase >= -PLIM));                      // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mag_done |=> !mag_done);                                               // R7
    AST_DONE_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mag_done, res_valid}));                                      // R7

endmodule

bind qcorr_top qcorr_checker #(
    .WIN(WIN), .TOT_W(TOT_W), .FRAC(FRAC), .PH_W(PH_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mag_done(mag_done), .res_valid(res_valid),
    .sin_total(sin_total), .cos_total(cos_total), .magnitude(magnitude),
    .phase(phase), .fill_cnt(fill_cnt)
);

// File: tb/qcorr_top_tb_top.sv
module qcorr_top_tb_top;

    localparam int WIN = 120;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic [11:0]        smp_code = '0;
    logic               mag_done, res_valid;
    logic signed [20:0] sin_total, cos_total;
    logic [20:0]        magnitude;
    logic signed [16:0] phase;

    int checks = 0;
    int failures = 0;
    int n_done = 0;
    int n_valid = 0;
    bit finished = 0;

    // reference model state
    longint ms [WIN];
    longint mc [WIN];
    int     mptr, mfill;
    longint msin, mcos;

    always #4 clk = ~clk;

    qcorr_top dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .mag_done(mag_done), .res_valid(res_valid), .sin_total(sin_total),
        .cos_total(cos_total), .magnitude(magnitude), .phase(phase)
    );

    always @(negedge clk) begin
        if (rst_n && mag_done)  n_done++;
        if (rst_n && res_valid) n_valid++;
    end

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint fsqrt(longint x);
        longint r = 0;
        for (int b = 21; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= x) r = t;
        end
        return r;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < WIN; i++) begin ms[i] = 0; mc[i] = 0; end
        mptr = 0; mfill = 0; msin = 0; mcos = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        n_done = 0; n_valid = 0;
        @(negedge clk);
    endtask

    task automatic drive(int code);
        smp_valid = 1'b1; smp_code = 12'(code);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (15) @(negedge clk);
    endtask

    // one carrier cycle, then wait for the result and compare everything
    task automatic run_group(int c0, int c1, int c2, int c3);
        int d0 = n_done;
        int v0 = n_valid;
        longint ssum, csum, emag, eph, a;
        drive(c0); drive(c1); drive(c2); drive(c3);
        repeat (40) @(negedge clk);
        csum = longint'(c0 - 2048) - longint'(c2 - 2048);   // R1 R2
        ssum = longint'(c1 - 2048) - longint'(c3 - 2048);   // R1 R3
        msin = msin + ssum - ms[mptr];                      // R5
        mcos = mcos + csum - mc[mptr];
        ms[mptr] = ssum; mc[mptr] = csum;
        mptr = (mptr + 1) % WIN;
        if (mfill < WIN) mfill++;
        emag = fsqrt(msin * msin + mcos * mcos);
        a = (msin < 0) ? -msin : msin;
        eph = (emag == 0) ? 0 : (a * 32768) / emag;
        if (msin < 0) eph = -eph;
        check("R3 R4 sin_total", longint'(sin_total), msin);
        check("R2 R4 cos_total", longint'(cos_total), mcos);
        check("R6 magnitude", longint'(magnitude), emag);
        check("R8 phase", longint'(phase), eph);
        check("R7 mag_done count", n_done - d0, 1);
        check("R9 res_valid count", n_valid - v0, (mfill == WIN) ? 1 : 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 reset sin_total", longint'(sin_total), 0);
        check("R10 reset cos_total", longint'(cos_total), 0);
        check("R10 reset magnitude", longint'(magnitude), 0);
        check("R10 reset phase", longint'(phase), 0);
        check("R10 reset res_valid", longint'(res_valid), 0);
    endtask

    task automatic t_offset();
        do_reset();
        run_group(2053, 2048, 2048, 2048);   // R1: cos sum 5
        check("R1 offset cos_total", longint'(cos_total), 5);
        run_group(2048, 2041, 2048, 2048);   // R1: sin sum -7
        check("R1 offset sin_total", longint'(sin_total), -7);
    endtask

    task automatic t_cosine_then_sine();
        do_reset();
        for (int g = 0; g < WIN; g++) begin
            run_group(3048, 2048, 1048, 2048);
            if (g == WIN - 2) check("R9 no valid before fill", n_valid, 0);
        end
        check("R9 first valid at fill", n_valid, 1);
        check("R2 cosine total", longint'(cos_total), 240000);
        check("R8 cosine phase", longint'(phase), 0);
        for (int g = 0; g < 30; g++) run_group(2048, 2548, 2048, 1548);
        check("R5 slide cos_total", longint'(cos_total), 90 * 2000);
        check("R5 slide sin_total", longint'(sin_total), 30 * 1000);
    endtask

    task automatic t_extremes();
        do_reset();
        for (int g = 0; g < WIN; g++) run_group(4095, 0, 0, 4095);
        check("R3 full-scale sin_total", longint'(sin_total), -491400);
        check("R8 negative phase sign", longint'(phase < 0), 1);
    endtask

    task automatic t_dc();
        do_reset();
        for (int g = 0; g < 8; g++) run_group(3000, 3000, 3000, 3000);
        check("R8 zero magnitude phase", longint'(phase), 0);
        check("R6 zero magnitude", longint'(magnitude), 0);
    endtask

    task automatic t_mid_reset();
        do_reset();
        for (int g = 0; g < 20; g++) run_group(2048, 2800, 2048, 1300);
        do_reset();
        check("R10 mid reset sin_total", longint'(sin_total), 0);
        for (int g = 0; g < 5; g++) run_group(2100, 2048, 2000, 2048);
        check("R10 ring emptied", longint'(cos_total), 5 * 100);
        check("R9 no valid after reset", n_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_offset();
        t_cosine_then_sine();
        t_extremes();
        t_dc();
        t_mid_reset();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule